// File: doc/BRIEF.md
# Interconnect Error Capture Unit

This unit sits beside a memory interconnect and records two classes of fault. The first is a local access error: a transaction that matched no address window, or matched a window whose target is not valid. The second is a coherency violation: a transaction that found a cache line in an illegal state. Each class has a sticky status bit. The first enabled fault also freezes a snapshot of the offending transaction, which holds the full address, the source identifier, a capture type, an unavailable-target flag and one 32-bit auxiliary attribute word. A level interrupt is raised from the status bits and held until software clears them.

Software reaches the unit through a bank of seven 32-bit words on a plain single-cycle bus. Reads are combinational on the word address, and writes take effect at the clock edge. The `STYLE` parameter selects one of two register personalities. In the enable personality, a 1 in the control word turns detection on, and the same bits also gate the interrupt. In the disable personality, a 1 in the control word turns detection off, and a separate interrupt-enable word masks the interrupt while detection keeps running. Fault events arrive as single-cycle pulses with their attributes valid in the same cycle. No back-pressure is applied, and an event is never refused, only filtered by the detection controls.

Top module: `fab_err_unit`

## Requirements
- R1: After reset, every word of the bank reads 0 and `irq` is low. Detection is off in the enable personality and on in the disable personality, and interrupts are masked in the disable personality.
- R2: The word at byte offset 0x00 holds the status bits: bit 0 is the local access error and bit 1 is the coherency violation. A status bit sets on an enabled event of its class. Writing 1 to a status bit clears only that bit, and writing 0 leaves it unchanged.
- R3: In the enable personality, the control word at 0x04 uses bit 0 for the local access error and bit 1 for the coherency violation. A 0 in a bit makes events of that class ignored: no status bit is set and no capture is taken.
- R4: In the disable personality, a 1 in a control bit at 0x04 (same bit order) stops detection of that class. Such events leave the status bits and the capture untouched.
- R5: In the disable personality, the interrupt-enable word at 0x08 (same bit order) masks `irq` without stopping detection. In the enable personality, 0x08 reads 0.
- R6: In the enable personality, `irq` is high when a status bit is set and its control bit is 1. Clearing the control bit drops `irq`, and the status bit stays set.
- R7: Only the first enabled fault loads the capture. While the capture is valid, later faults still set status bits but leave the captured address and attributes unchanged.
- R8: In the disable personality, the capture-valid flag reads at bit 31 of 0x00 and the 5-bit capture type at bits 30:26. Writing 1 to bit 31 clears the valid flag, after which the next enabled fault is captured.
- R9: In the enable personality, the attribute word at 0x0C carries the valid flag in bit 0, the unavailable-target flag in bit 15 and the source ID in bits 31:24. The unavailable-target flag is recorded only for a local access error. Writing 1 to bit 0 of 0x0C clears the valid flag.
- R10: In the disable personality, the source ID reads at bits 25:18 of 0x0C.
- R11: The captured address reads with its upper bits in the low 8 bits of 0x10, which reads 0 elsewhere, and its low 32 bits at 0x14. The auxiliary attribute word reads at 0x18.
- R12: `irq` is a level that stays high until the status bits behind it are cleared, and it is never high with all status bits clear.
- R13: When a write-1-to-clear of a status bit meets an enabled event of the same class in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_lae | input | 1 | Local access error event pulse |
| ev_cv | input | 1 | Coherency violation event pulse |
| ev_unavail | input | 1 | Event was caused by an unavailable target ID |
| ev_addr | input | ADDR_W | Physical address of the faulting transaction |
| ev_src | input | SRC_W | Source identifier of the faulting transaction |
| ev_type | input | TYPE_W | Capture type code of the faulting transaction |
| ev_aux | input | AUX_W | Auxiliary attribute word of the faulting transaction |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the places where a faulty unit would corrupt the record. A later fault must not overwrite a valid capture, or the report would name the wrong address and source. A partial write-1-to-clear must clear only the bits written, or a pending fault would be lost. An event that arrives in the same cycle as a clear must not be dropped. Both personalities are driven, because an inverted control polarity or an interrupt mask that also stopped detection would leave the status bits wrong in one of them. Field placement is checked in both personalities: a source ID at the wrong offset or a leaked unavailable-target flag on a coherency fault would show up as a mismatched word.

// File: rtl/fab_err_pkg.sv
package fab_err_pkg;

  typedef enum logic {
    STYLE_ENABLE  = 1'b0,
    STYLE_DISABLE = 1'b1
  } ctl_style_e;

  localparam int NUM_ERR = 2;
  localparam int ERR_LAE = 0;
  localparam int ERR_CV  = 1;

  localparam logic [2:0] W_DET   = 3'd0;
  localparam logic [2:0] W_CTL   = 3'd1;
  localparam logic [2:0] W_IEN   = 3'd2;
  localparam logic [2:0] W_ATTR  = 3'd3;
  localparam logic [2:0] W_AHI   = 3'd4;
  localparam logic [2:0] W_ALO   = 3'd5;
  localparam logic [2:0] W_ATTR2 = 3'd6;

  localparam int DET_VALID_BIT  = 31;
  localparam int DET_TYPE_LSB   = 26;
  localparam int ATTR_VALID_BIT = 0;
  localparam int ATTR_UNAV_BIT  = 15;
  localparam int SRC_LSB_EN     = 24;
  localparam int SRC_LSB_DIS    = 18;

endpackage

// File: rtl/fab_err_status.sv
module fab_err_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] det
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               det[g] <= 1'b0;
      else if (evt[g] && en[g]) det[g] <= 1'b1;
      else if (clr[g])          det[g] <= 1'b0;
    end

    // R2 / R13: a set bit stays set unless a clear is written
    assert_det_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (det[g] && !clr[g]) |=> det[g]);

    // R3 / R4: with detection off, a clear bit stays clear
    assert_off_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!det[g] && !en[g]) |=> !det[g]);
  end

endmodule

// File: rtl/fab_err_capture.sv
module fab_err_capture #(
  parameter int ADDR_W = 40,
  parameter int SRC_W  = 8,
  parameter int TYPE_W = 5,
  parameter int AUX_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              clr_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [TYPE_W-1:0] in_type,
  input  logic              in_unav,
  input  logic [AUX_W-1:0]  in_aux,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [SRC_W-1:0]  cap_src,
  output logic [TYPE_W-1:0] cap_type,
  output logic              cap_unav,
  output logic [AUX_W-1:0]  cap_aux
);

  logic load;
  assign load = hit && !cap_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_valid <= 1'b0;
    else if (load)      cap_valid <= 1'b1;
    else if (clr_valid) cap_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_src  <= '0;
      cap_type <= '0;
      cap_unav <= 1'b0;
      cap_aux  <= '0;
    end else if (load) begin
      cap_addr <= in_addr;
      cap_src  <= in_src;
      cap_type <= in_type;
      cap_unav <= in_unav;
      cap_aux  <= in_aux;
    end
  end

  // R7: a valid capture is never overwritten
  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> ($stable(cap_addr) && $stable(cap_src) && $stable(cap_aux)));

  // R8: the first enabled fault marks the capture valid
  assert_capture_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cap_valid) |=> cap_valid);

endmodule

// File: rtl/fab_err_regs.sv
module fab_err_regs
  import fab_err_pkg::*;
#(
  parameter ctl_style_e STYLE  = STYLE_DISABLE,
  parameter int         N      = 2,
  parameter int         ADDR_W = 40,
  parameter int         SRC_W  = 8,
  parameter int         TYPE_W = 5,
  parameter int         AUX_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [N-1:0]      det,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [SRC_W-1:0]  cap_src,
  input  logic [TYPE_W-1:0] cap_type,
  input  logic              cap_unav,
  input  logic [AUX_W-1:0]  cap_aux,
  output logic [N-1:0]      ctl,
  output logic [N-1:0]      inten,
  output logic [N-1:0]      clr_det,
  output logic              clr_valid
);

  localparam int HI_W = ADDR_W - 32;

  logic [2:0] word;
  logic       wr_det, wr_ctl, wr_ien, wr_attr;
  logic [31:0] det_word, attr_word, ahi_word;
  logic        unused_bits;

  assign word    = addr[4:2];
  assign wr_det  = wr_en && (word == W_DET);
  assign wr_ctl  = wr_en && (word == W_CTL);
  assign wr_ien  = wr_en && (word == W_IEN);
  assign wr_attr = wr_en && (word == W_ATTR);
  assign clr_det = wr_det ? wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_ctl) ctl <= wdata[N-1:0];
  end

  always_comb begin
    ahi_word = '0;
    ahi_word[HI_W-1:0] = cap_addr[ADDR_W-1:32];
  end

  if (STYLE == STYLE_DISABLE) begin : g_dis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      inten <= '0;
      else if (wr_ien) inten <= wdata[N-1:0];
    end
    assign clr_valid = wr_det && wdata[DET_VALID_BIT];
    always_comb begin
      det_word = '0;
      det_word[N-1:0] = det;
      det_word[DET_VALID_BIT] = cap_valid;
      det_word[DET_TYPE_LSB +: TYPE_W] = cap_type;
      attr_word = '0;
      attr_word[SRC_LSB_DIS +: SRC_W] = cap_src;
    end
  end else begin : g_en
    assign inten     = '0;
    assign clr_valid = wr_attr && wdata[ATTR_VALID_BIT];
    always_comb begin
      det_word = '0;
      det_word[N-1:0] = det;
      attr_word = '0;
      attr_word[SRC_LSB_EN +: SRC_W] = cap_src;
      attr_word[ATTR_UNAV_BIT] = cap_unav;
      attr_word[ATTR_VALID_BIT] = cap_valid;
    end
  end

  always_comb begin
    rdata = '0;
    case (word)
      W_DET:   rdata = det_word;
      W_CTL:   rdata[N-1:0] = ctl;
      W_IEN:   rdata[N-1:0] = inten;
      W_ATTR:  rdata = attr_word;
      W_AHI:   rdata = ahi_word;
      W_ALO:   rdata = cap_addr[31:0];
      W_ATTR2: rdata[AUX_W-1:0] = cap_aux;
      default: rdata = '0;
    endcase
  end

  assign unused_bits = ^{wdata, addr[1:0], cap_unav, cap_type, wr_attr, wr_ien};

endmodule

// File: rtl/fab_err_unit.sv
module fab_err_unit
  import fab_err_pkg::*;
#(
  parameter ctl_style_e STYLE  = STYLE_DISABLE,
  parameter int         ADDR_W = 40,
  parameter int         SRC_W  = 8,
  parameter int         TYPE_W = 5,
  parameter int         AUX_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_lae,
  input  logic              ev_cv,
  input  logic              ev_unavail,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [SRC_W-1:0]  ev_src,
  input  logic [TYPE_W-1:0] ev_type,
  input  logic [AUX_W-1:0]  ev_aux,
  input  logic              bus_wr_en,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam int N = NUM_ERR;

  logic [N-1:0] evt, en, det, ctl, inten, clr_det, irq_mask;
  logic         hit, clr_valid, unav_in;
  logic              cap_valid, cap_unav;
  logic [ADDR_W-1:0] cap_addr;
  logic [SRC_W-1:0]  cap_src;
  logic [TYPE_W-1:0] cap_type;
  logic [AUX_W-1:0]  cap_aux;

  always_comb begin
    evt = '0;
    evt[ERR_LAE] = ev_lae;
    evt[ERR_CV]  = ev_cv;
  end

  if (STYLE == STYLE_ENABLE) begin : g_pol_en
    assign en       = ctl;
    assign irq_mask = ctl;
  end else begin : g_pol_dis
    assign en       = ~ctl;
    assign irq_mask = inten;
  end

  assign hit     = |(evt & en);
  assign unav_in = ev_unavail && evt[ERR_LAE] && en[ERR_LAE];
  assign irq     = |(det & irq_mask);

  fab_err_status #(.N(N)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en(en), .clr(clr_det), .det(det)
  );

  fab_err_capture #(
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .TYPE_W(TYPE_W), .AUX_W(AUX_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_valid(clr_valid),
    .in_addr(ev_addr), .in_src(ev_src), .in_type(ev_type),
    .in_unav(unav_in), .in_aux(ev_aux),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_src(cap_src),
    .cap_type(cap_type), .cap_unav(cap_unav), .cap_aux(cap_aux)
  );

  fab_err_regs #(
    .STYLE(STYLE), .N(N), .ADDR_W(ADDR_W), .SRC_W(SRC_W),
    .TYPE_W(TYPE_W), .AUX_W(AUX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .det(det),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_src(cap_src),
    .cap_type(cap_type), .cap_unav(cap_unav), .cap_aux(cap_aux),
    .ctl(ctl), .inten(inten), .clr_det(clr_det), .clr_valid(clr_valid)
  );

  // R12: the interrupt always has a pending status bit behind it
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (det != '0));

  // R1: status and capture start clear
  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (det == '0 && !cap_valid);
  end

endmodule

// File: tb/test_fab_err_unit.sv
`timescale 1ns/100ps
module test_fab_err_unit;
  import fab_err_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_lae = 0, ev_cv = 0, ev_unavail = 0;
  logic [39:0] ev_addr = '0;
  logic [7:0]  ev_src = '0;
  logic [4:0]  ev_type = '0;
  logic [31:0] ev_aux = '0;
  logic        wr_en_d = 0, wr_en_e = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_d, rdata_e;
  logic        irq_d, irq_e;
  logic        sel = 1'b1;
  logic        rd_go = 1'b0;
  int          checks = 0, failures = 0;
  bit          done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  fab_err_unit i_fab_err_unit (
    .clk(clk), .rst_n(rst_n), .ev_lae(ev_lae), .ev_cv(ev_cv),
    .ev_unavail(ev_unavail), .ev_addr(ev_addr), .ev_src(ev_src),
    .ev_type(ev_type), .ev_aux(ev_aux), .bus_wr_en(wr_en_d),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_d), .irq(irq_d)
  );

  fab_err_unit #(.STYLE(STYLE_ENABLE)) i_fab_err_unit_en (
    .clk(clk), .rst_n(rst_n), .ev_lae(ev_lae), .ev_cv(ev_cv),
    .ev_unavail(ev_unavail), .ev_addr(ev_addr), .ev_src(ev_src),
    .ev_type(ev_type), .ev_aux(ev_aux), .bus_wr_en(wr_en_e),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_e), .irq(irq_e)
  );

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rd_go) begin
      logic [31:0] got, exp;
      string t;
      got = sel ? rdata_d : rdata_e;
      exp = exp_q.pop_front();
      t   = tag_q.pop_front();
      checks++;
      if (got !== exp) begin
        failures++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, got, exp);
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_go = 1'b1;
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (sel) wr_en_d = 1'b1; else wr_en_e = 1'b1;
    @(negedge clk);
    wr_en_d = 1'b0; wr_en_e = 1'b0;
  endtask

  task automatic ev(input logic lae, input logic cv, input logic un,
                    input logic [39:0] a, input logic [7:0] s,
                    input logic [4:0] ty, input logic [31:0] x);
    @(negedge clk);
    ev_lae = lae; ev_cv = cv; ev_unavail = un;
    ev_addr = a; ev_src = s; ev_type = ty; ev_aux = x;
    @(negedge clk);
    ev_lae = 0; ev_cv = 0; ev_unavail = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    logic got;
    @(negedge clk);
    got = sel ? irq_d : irq_e;
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: irq got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state, both personalities
    for (int w = 0; w < 7; w++) begin
      sel = 1'b1; rd(5'(w*4), 32'h0, "R1 disable-style reset word");
      sel = 1'b0; rd(5'(w*4), 32'h0, "R1 enable-style reset word");
    end
    chk_irq(1'b0, "R1 enable-style irq");
    sel = 1'b1;
    chk_irq(1'b0, "R1 disable-style irq");

    // ---- disable personality ----
    ev(1, 0, 0, 40'hA5_1234_5678, 8'h3C, 5'h11, 32'hDEAD_BEEF);
    rd(5'h00, 32'hC400_0001, "R8 status with valid and type");
    rd(5'h0C, 32'h00F0_0000, "R10 source at 25:18");
    rd(5'h10, 32'h0000_00A5, "R11 address high");
    rd(5'h14, 32'h1234_5678, "R11 address low");
    rd(5'h18, 32'hDEAD_BEEF, "R11 aux word");
    chk_irq(1'b0, "R5 masked irq with detection on");
    wr(5'h08, 32'h3);
    chk_irq(1'b1, "R5 unmasked irq");
    ev(0, 1, 0, 40'h11_0000_0004, 8'h77, 5'h02, 32'h1);
    rd(5'h00, 32'hC400_0003, "R2 second class sets");
    rd(5'h14, 32'h1234_5678, "R7 capture held");
    rd(5'h0C, 32'h00F0_0000, "R7 source held");
    wr(5'h00, 32'h1);
    rd(5'h00, 32'hC400_0002, "R2 partial clear");
    chk_irq(1'b1, "R12 level held");
    wr(5'h00, 32'h8000_0002);
    rd(5'h00, 32'h4400_0000, "R8 valid cleared");
    chk_irq(1'b0, "R12 irq drops when cleared");
    ev(0, 1, 0, 40'h11_0000_0004, 8'h77, 5'h02, 32'h1);
    rd(5'h00, 32'h8800_0002, "R8 recapture after clear");
    rd(5'h14, 32'h0000_0004, "R8 new address low");
    rd(5'h10, 32'h0000_0011, "R11 new address high");
    rd(5'h0C, 32'h01DC_0000, "R10 new source");
    wr(5'h00, 32'h8000_0002);
    wr(5'h04, 32'h2);
    ev(0, 1, 0, 40'h22_0000_0008, 8'h55, 5'h07, 32'h2);
    rd(5'h00, 32'h0800_0000, "R4 disabled class ignored");
    rd(5'h14, 32'h0000_0004, "R4 no capture when disabled");
    chk_irq(1'b0, "R4 no irq when disabled");
    ev(1, 0, 0, 40'h33_0000_0010, 8'h10, 5'h1F, 32'h3);
    rd(5'h00, 32'hFC00_0001, "R4 other class still detected");
    // R13 clear and event in the same cycle
    @(negedge clk);
    bus_addr = 5'h00; bus_wdata = 32'h1; wr_en_d = 1'b1;
    ev_lae = 1'b1; ev_addr = 40'h44_0000_0000;
    @(negedge clk);
    wr_en_d = 1'b0; ev_lae = 1'b0;
    rd(5'h00, 32'hFC00_0001, "R13 set wins over clear");
    wr(5'h00, 32'h1);
    rd(5'h00, 32'hFC00_0000, "R13 later clear works");

    // ---- enable personality ----
    do_reset();
    sel = 1'b0;
    ev(1, 0, 1, 40'h5A_CAFE_F00D, 8'hAB, 5'h03, 32'h0BAD_0000);
    rd(5'h00, 32'h0, "R3 ignored while disabled");
    rd(5'h0C, 32'h0, "R3 no capture while disabled");
    chk_irq(1'b0, "R3 no irq while disabled");
    wr(5'h04, 32'h3);
    ev(1, 0, 1, 40'h5A_CAFE_F00D, 8'hAB, 5'h03, 32'h0BAD_0000);
    rd(5'h00, 32'h0000_0001, "R2 enable-style status");
    rd(5'h0C, 32'hAB00_8001, "R9 attr src/unavail/valid");
    rd(5'h10, 32'h0000_005A, "R11 enable-style address high");
    rd(5'h18, 32'h0BAD_0000, "R11 enable-style aux");
    rd(5'h08, 32'h0, "R5 no interrupt-enable word");
    chk_irq(1'b1, "R6 irq on enabled status");
    ev(0, 1, 0, 40'h01_0000_0000, 8'h01, 5'h00, 32'h0);
    rd(5'h00, 32'h0000_0003, "R7 enable-style second status");
    rd(5'h0C, 32'hAB00_8001, "R7 enable-style capture held");
    wr(5'h04, 32'h0);
    chk_irq(1'b0, "R6 irq drops with control");
    rd(5'h00, 32'h0000_0003, "R6 status kept after control off");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'hAB00_8000, "R9 valid cleared");
    wr(5'h04, 32'h3);
    chk_irq(1'b1, "R6 irq returns");
    wr(5'h00, 32'h3);
    rd(5'h00, 32'h0, "R2 enable-style clear");
    chk_irq(1'b0, "R12 enable-style irq cleared");
    ev(0, 1, 1, 40'h02_0000_0000, 8'h42, 5'h00, 32'h0);
    rd(5'h0C, 32'h4200_0001, "R9 unavail only for local access");
    rd(5'h00, 32'h0000_0002, "R2 coherency bit position");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule